// File: doc/BRIEF.md
# Memory Bitfield Operation Unit

This unit carries out one bitfield operation at a time on a field that lives in byte-addressed memory. A field is given by a byte address, a signed bit offset counted from the most significant bit of that byte, and a 5-bit length code. The unit finds the byte window that covers the field, which may start before the given byte when the offset is negative. It reads that window one byte at a time through a request/acknowledge memory port and computes the result.

The seven operations are signed extract, unsigned extract, insert, invert, clear, fill and find-first-one. The four modifying operations write the whole window back, changing only the field bits. Every operation returns a 32-bit result and a second 32-bit word that holds the field bits aligned to bit 31, which a flag stage can use.

A caller drives the operands with a one-cycle `start` while `busy` is low. It then waits for the one-cycle `done` pulse, after which `result` and `flag_field` stay valid until the next operation.

Top module: `bitfield_mem_unit`

## Requirements
- R1: During and right after reset, and whenever the unit is idle, `busy`, `done` and `mem_req` are low. A reset in the middle of an operation abandons it.
- R2: A length code of 0 selects a 32-bit field; codes 1 to 31 select that many bits.
- R3: The first byte accessed is `base_addr + floor(bit_ofs / 8)`, and the bit position within it is `bit_ofs mod 8` in the range 0 to 7. A negative offset therefore borrows one byte whenever it is not a multiple of 8.
- R4: The number of bytes read is `(bitpos + len - 1) / 8 + 1`, where bitpos is the value from R3. This is 1 to 5 bytes, read at ascending consecutive addresses. A modifying operation writes back the same bytes in the same order.
- R5: Field bit 0 is the most significant bit (bit 7) of the first byte. Later field bits run toward lower bit numbers and then into higher addresses.
- R6: Op 0 (signed extract) returns the field sign-extended to 32 bits. Op 1 returns it zero-extended, and op 7 acts as op 1. For ops 0, 1 and 7, `flag_field` holds the field in its top `len` bits and zeros below.
- R7: Op 2 (insert) writes the low `len` bits of `ins_val` into the field. It returns those bits zero-extended in `result`, and the same bits top-aligned in `flag_field`.
- R8: Ops 3, 4 and 5 invert, clear or fill the field in memory. Each returns the original field zero-extended in `result` and top-aligned in `flag_field`.
- R9: Op 6 (find-first-one) returns `bit_ofs` plus the number of leading zeros in the field, or `bit_ofs + len` if the field is all zero. The sum is modulo 2^32, and `flag_field` holds the top-aligned field.
- R10: Bits of the window outside the field are written back unchanged. No byte outside the window is accessed, and ops 0, 1, 6 and 7 issue no write.
- R11: `mem_addr`, `mem_we` and `mem_wdata` stay steady while `mem_req` waits for `mem_ack`. `done` lasts exactly one cycle per operation, and a `start` while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation with the present operands (idle only) |
| op | input | 3 | Operation code, see R6 to R9 |
| base_addr | input | ADDR_W | Base byte address |
| bit_ofs | input | 32 | Signed bit offset from bit 7 of the base byte |
| len_code | input | 5 | Field length, 0 meaning 32 |
| ins_val | input | 32 | Value for insert |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Operation result |
| flag_field | output | 32 | Field bits aligned to bit 31 |
| mem_req | output | 1 | Memory byte request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address of the request |
| mem_wdata | output | 8 | Write byte |
| mem_ack | input | 1 | Request completed this cycle |
| mem_rdata | input | 8 | Read byte, valid with mem_ack |

## Verification
The operations are run over offsets that stay inside one byte, cross one to four byte boundaries, start exactly on a byte boundary and are negative, with lengths 1, mid-range and 0 (32). These separate an error in the byte-count formula from an error in the floor division or in the big-endian bit order. Memory is preloaded with an irregular pattern, so a result taken from the wrong bit or byte does not match by chance. After every modifying operation the whole memory image is compared, which exposes any disturbed neighbour bit or any stray byte written. Find-first-one is tried on a field with a set bit and on an all-zero field of lengths 8 and 32, which tells the leading-zero path apart from the length fallback.

// File: rtl/bfm_pkg.sv
package bfm_pkg;

  localparam int WORD_W    = 32;
  localparam int WIN_BYTES = WORD_W / 8 + 1;
  localparam int WIN_W     = WIN_BYTES * 8;
  localparam int IDX_W     = $clog2(WIN_BYTES);
  localparam int LEN_W     = $clog2(WORD_W) + 1;

  typedef enum logic [2:0] {
    BF_EXTS = 3'd0,
    BF_EXTU = 3'd1,
    BF_INS  = 3'd2,
    BF_CHG  = 3'd3,
    BF_CLR  = 3'd4,
    BF_SET  = 3'd5,
    BF_FFO  = 3'd6,
    BF_RSV  = 3'd7
  } bf_op_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_CALC  = 3'd2,
    ST_WRITE = 3'd3,
    ST_DONE  = 3'd4
  } bf_state_e;

  // Length code to bit count: zero stands for a full word.
  function automatic logic [LEN_W-1:0] bf_len(input logic [4:0] code);
    return (code == 5'd0) ? LEN_W'(WORD_W) : LEN_W'(code);
  endfunction

  // Ones in the top len bits of a word.
  function automatic logic [WORD_W-1:0] bf_topmask(input logic [LEN_W-1:0] len);
    return ~({WORD_W{1'b1}} >> len);
  endfunction

  // Leading zero count; all-zero input gives WORD_W.
  function automatic logic [LEN_W-1:0] bf_clz(input logic [WORD_W-1:0] v);
    logic [LEN_W-1:0] n;
    n = LEN_W'(WORD_W);
    for (int i = 0; i < WORD_W; i++) begin
      if (v[i]) n = LEN_W'(WORD_W - 1 - i);
    end
    return n;
  endfunction

  function automatic logic bf_is_rmw(input bf_op_e op);
    return (op == BF_INS) || (op == BF_CHG) || (op == BF_CLR) || (op == BF_SET);
  endfunction

endpackage

// File: rtl/bfm_locate.sv
module bfm_locate
  import bfm_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0]       base_addr,
  input  logic signed [WORD_W-1:0] bit_ofs,
  input  logic [4:0]              len_code,
  output logic [ADDR_W-1:0]       win_addr,
  output logic [2:0]              bit_sel,
  output logic [IDX_W-1:0]        span_m1,
  output logic [LEN_W-1:0]        fld_len
);

  logic signed [WORD_W-1:0] byte_step;
  logic [LEN_W:0]           last_bit;

  always_comb begin
    // Arithmetic shift is a floor division, so a negative remainder borrows.
    byte_step = bit_ofs >>> 3;
    win_addr  = base_addr + byte_step[ADDR_W-1:0];
    bit_sel   = bit_ofs[2:0];
    fld_len   = bf_len(len_code);
    last_bit  = (LEN_W+1)'(bit_sel) + (LEN_W+1)'(fld_len) - (LEN_W+1)'(1);
    span_m1   = IDX_W'(last_bit >> 3);
  end

endmodule

// File: rtl/bfm_datapath.sv
module bfm_datapath
  import bfm_pkg::*;
(
  input  bf_op_e                   op,
  input  logic [WIN_W-1:0]         window,
  input  logic [2:0]               bit_sel,
  input  logic [LEN_W-1:0]         fld_len,
  input  logic signed [WORD_W-1:0] bit_ofs,
  input  logic [WORD_W-1:0]        ins_val,
  output logic [WIN_W-1:0]         new_window,
  output logic [WORD_W-1:0]        result,
  output logic [WORD_W-1:0]        flag_field
);

  localparam int PAD = WIN_W - WORD_W;

  logic [WIN_W-1:0]  aligned;
  logic [WORD_W-1:0] tmask;
  logic [WORD_W-1:0] field_top;
  logic [LEN_W-1:0]  rsh;
  logic [WORD_W-1:0] ins_top;
  logic [WIN_W-1:0]  mask_w;
  logic [WIN_W-1:0]  ins_w;
  logic [LEN_W-1:0]  ffo_pos;
  logic [WORD_W-1:0] uval;
  logic [WORD_W-1:0] sval;

  always_comb begin
    aligned   = window << bit_sel;
    tmask     = bf_topmask(fld_len);
    field_top = aligned[WIN_W-1 -: WORD_W] & tmask;
    rsh       = LEN_W'(WORD_W) - fld_len;
    uval      = field_top >> rsh;
    sval      = WORD_W'($signed(field_top) >>> rsh);
    ins_top   = ins_val << rsh;
    mask_w    = {tmask, {PAD{1'b0}}} >> bit_sel;
    ins_w     = {ins_top, {PAD{1'b0}}} >> bit_sel;
    ffo_pos   = (field_top == '0) ? fld_len : bf_clz(field_top);

    new_window = window;
    result     = uval;
    flag_field = field_top;
    unique case (op)
      BF_EXTS: result = sval;
      BF_INS: begin
        new_window = (window & ~mask_w) | ins_w;
        result     = ins_top >> rsh;
        flag_field = ins_top;
      end
      BF_CHG: new_window = window ^ mask_w;
      BF_CLR: new_window = window & ~mask_w;
      BF_SET: new_window = window | mask_w;
      BF_FFO: result = bit_ofs + WORD_W'(ffo_pos);
      default: result = uval;
    endcase
  end

endmodule

// File: rtl/bfm_seq.sv
module bfm_seq
  import bfm_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [2:0]               op_in,
  input  logic [ADDR_W-1:0]        base_in,
  input  logic [WORD_W-1:0]        ofs_in,
  input  logic [4:0]               len_in,
  input  logic [WORD_W-1:0]        ins_in,
  output bf_op_e                   op_q,
  output logic [ADDR_W-1:0]        base_q,
  output logic signed [WORD_W-1:0] ofs_q,
  output logic [4:0]               len_q,
  output logic [WORD_W-1:0]        ins_q,
  input  logic [ADDR_W-1:0]        win_addr,
  input  logic [IDX_W-1:0]         span_m1,
  input  logic [WIN_W-1:0]         new_window,
  input  logic [WORD_W-1:0]        result_c,
  input  logic [WORD_W-1:0]        flag_c,
  input  logic                     is_rmw,
  output logic [WIN_W-1:0]         window_q,
  output logic                     busy,
  output logic                     done,
  output logic [WORD_W-1:0]        result,
  output logic [WORD_W-1:0]        flag_field,
  output logic                     mem_req,
  output logic                     mem_we,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [7:0]               mem_wdata,
  input  logic                     mem_ack,
  input  logic [7:0]               mem_rdata
);

  bf_state_e        state;
  logic [IDX_W-1:0] idx;
  logic             last_byte;

  assign last_byte = (idx == span_m1);
  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_DONE);
  assign mem_req   = (state == ST_READ) || (state == ST_WRITE);
  assign mem_we    = (state == ST_WRITE);
  assign mem_addr  = win_addr + ADDR_W'(idx);

  always_comb begin
    mem_wdata = '0;
    for (int b = 0; b < WIN_BYTES; b++) begin
      if (idx == IDX_W'(b)) mem_wdata = window_q[WIN_W-1-8*b -: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      idx        <= '0;
      window_q   <= '0;
      op_q       <= BF_EXTU;
      base_q     <= '0;
      ofs_q      <= '0;
      len_q      <= '0;
      ins_q      <= '0;
      result     <= '0;
      flag_field <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            op_q     <= bf_op_e'(op_in);
            base_q   <= base_in;
            ofs_q    <= ofs_in;
            len_q    <= len_in;
            ins_q    <= ins_in;
            idx      <= '0;
            window_q <= '0;
            state    <= ST_READ;
          end
        end
        ST_READ: begin
          if (mem_ack) begin
            for (int b = 0; b < WIN_BYTES; b++) begin
              if (idx == IDX_W'(b)) window_q[WIN_W-1-8*b -: 8] <= mem_rdata;
            end
            if (last_byte) state <= ST_CALC;
            else           idx   <= idx + 1'b1;
          end
        end
        ST_CALC: begin
          result     <= result_c;
          flag_field <= flag_c;
          idx        <= '0;
          if (is_rmw) begin
            window_q <= new_window;
            state    <= ST_WRITE;
          end else begin
            state    <= ST_DONE;
          end
        end
        ST_WRITE: begin
          if (mem_ack) begin
            if (last_byte) state <= ST_DONE;
            else           idx   <= idx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bitfield_mem_unit.sv
module bitfield_mem_unit
  import bfm_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [31:0]       bit_ofs,
  input  logic [4:0]        len_code,
  input  logic [31:0]       ins_val,
  output logic              busy,
  output logic              done,
  output logic [31:0]       result,
  output logic [31:0]       flag_field,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic              mem_ack,
  input  logic [7:0]        mem_rdata
);

  bf_op_e                   op_q;
  logic [ADDR_W-1:0]        base_q;
  logic signed [WORD_W-1:0] ofs_q;
  logic [4:0]               len_q;
  logic [WORD_W-1:0]        ins_q;
  logic [ADDR_W-1:0]        win_addr;
  logic [2:0]               bit_sel;
  logic [IDX_W-1:0]         span_m1;
  logic [LEN_W-1:0]         fld_len;
  logic [WIN_W-1:0]         window_q;
  logic [WIN_W-1:0]         new_window;
  logic [WORD_W-1:0]        result_c;
  logic [WORD_W-1:0]        flag_c;
  logic                     is_rmw;

  assign is_rmw = bf_is_rmw(op_q);

  bfm_locate #(.ADDR_W(ADDR_W)) u_locate (
    .base_addr (base_q),
    .bit_ofs   (ofs_q),
    .len_code  (len_q),
    .win_addr  (win_addr),
    .bit_sel   (bit_sel),
    .span_m1   (span_m1),
    .fld_len   (fld_len)
  );

  bfm_datapath u_datapath (
    .op         (op_q),
    .window     (window_q),
    .bit_sel    (bit_sel),
    .fld_len    (fld_len),
    .bit_ofs    (ofs_q),
    .ins_val    (ins_q),
    .new_window (new_window),
    .result     (result_c),
    .flag_field (flag_c)
  );

  bfm_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .op_in      (op),
    .base_in    (base_addr),
    .ofs_in     (bit_ofs),
    .len_in     (len_code),
    .ins_in     (ins_val),
    .op_q       (op_q),
    .base_q     (base_q),
    .ofs_q      (ofs_q),
    .len_q      (len_q),
    .ins_q      (ins_q),
    .win_addr   (win_addr),
    .span_m1    (span_m1),
    .new_window (new_window),
    .result_c   (result_c),
    .flag_c     (flag_c),
    .is_rmw     (is_rmw),
    .window_q   (window_q),
    .busy       (busy),
    .done       (done),
    .result     (result),
    .flag_field (flag_field),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata)
  );

endmodule

// File: rtl/bfm_checker.sv
module bfm_checker
  import bfm_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        mem_wdata,
  input logic [ADDR_W-1:0] win_addr,
  input logic [IDX_W-1:0]  span_m1,
  input logic              is_rmw
);

  logic [ADDR_W-1:0] rel_addr;
  assign rel_addr = mem_addr - win_addr;

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);  // R1
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));  // R11
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R11
  AST_WRITE_ONLY_RMW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> is_rmw);  // R10
  AST_ADDR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> rel_addr <= ADDR_W'(span_m1));  // R4
  AST_SPAN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> span_m1 <= IDX_W'(WIN_BYTES - 1));  // R4

endmodule

bind bitfield_mem_unit bfm_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .win_addr  (win_addr),
  .span_m1   (span_m1),
  .is_rmw    (is_rmw)
);

// File: tb/bitfield_mem_unit_test.sv
module bitfield_mem_unit_test;

  localparam int ADDR_W  = 16;
  localparam int MEM_N   = 64;
  localparam int NVEC    = 15;
  localparam int WD_CYC  = 150000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [2:0]        op = 3'd0;
  logic [ADDR_W-1:0] base_addr = '0;
  logic [31:0]       bit_ofs = '0;
  logic [4:0]        len_code = '0;
  logic [31:0]       ins_val = '0;
  logic              busy, done, mem_req, mem_we;
  logic [31:0]       result, flag_field;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0]        mem_wdata;
  logic              mem_ack = 1'b0;
  logic [7:0]        mem_rdata = '0;

  always #10 clk = ~clk;  // 50 MHz

  bitfield_mem_unit #(.ADDR_W(ADDR_W)) uut (.*);

  logic [7:0] mem   [MEM_N];
  logic [7:0] model [MEM_N];
  int rd_cnt, wr_cnt, first_rd;
  int n_chk = 0, n_fail = 0;

  // Byte-wide responder: acknowledges one cycle after a request.
  always @(posedge clk) begin
    if (!rst_n) mem_ack <= 1'b0;
    else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        mem[mem_addr[5:0]] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        mem_rdata <= mem[mem_addr[5:0]];
        if (rd_cnt == 0) first_rd <= int'(mem_addr);
        rd_cnt <= rd_cnt + 1;
      end
    end else mem_ack <= 1'b0;
  end

  // {op, base, ofs, len_code, ins}
  localparam logic [63:0] VEC [NVEC] = '{
    {3'd0, 8'd20, 16'sd3,   5'd5,  32'h0},
    {3'd1, 8'd20, 16'sd3,   5'd5,  32'h0},
    {3'd1, 8'd20, 16'sd0,   5'd0,  32'h0},
    {3'd1, 8'd20, 16'sd7,   5'd0,  32'h0},
    {3'd0, 8'd20, -16'sd1,  5'd4,  32'h0},
    {3'd1, 8'd20, -16'sd13, 5'd9,  32'h0},
    {3'd2, 8'd24, 16'sd5,   5'd12, 32'h000ABCDE},
    {3'd2, 8'd24, -16'sd3,  5'd0,  32'h12345678},
    {3'd3, 8'd30, 16'sd6,   5'd10, 32'h0},
    {3'd4, 8'd30, 16'sd2,   5'd3,  32'h0},
    {3'd5, 8'd30, 16'sd9,   5'd20, 32'h0},
    {3'd6, 8'd33, 16'sd4,   5'd12, 32'h0},
    {3'd6, 8'd33, -16'sd20, 5'd8,  32'h0},
    {3'd0, 8'd40, 16'sd1,   5'd1,  32'h0},
    {3'd7, 8'd40, 16'sd100, 5'd17, 32'h0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic fill_mem(input bit zero);
    for (int i = 0; i < MEM_N; i++) begin
      mem[i]   = zero ? 8'h00 : 8'((i * 29 + 90) ^ (i << 3));
      model[i] = mem[i];
    end
    rd_cnt = 0; wr_cnt = 0; first_rd = -1;
  endtask

  function automatic bit mbit(input int q);
    return model[q >>> 3][7 - (q & 7)];
  endfunction

  function automatic string op_tag(input logic [2:0] o);
    case (o)
      3'd0, 3'd1, 3'd7: return "R6";
      3'd2:             return "R7";
      3'd6:             return "R9";
      default:          return "R8";
    endcase
  endfunction

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; break; end
    end
  endtask

  task automatic run_op(input logic [2:0] o, input int base, input int ofs,
                        input logic [4:0] lc, input logic [31:0] iv, input bit zero_mem);
    int L, p, ffo, nb;
    logic [31:0] f, er, ef;
    bit ok;
    fill_mem(zero_mem);
    L = (lc == 0) ? 32 : int'(lc);  // R2
    p = base * 8 + ofs;
    f = 0; ffo = L;
    for (int i = L - 1; i >= 0; i--) if (mbit(p + i)) ffo = i;
    for (int i = 0; i < L; i++) f = (f << 1) | 32'(mbit(p + i));  // R5 big-endian order
    ef = f << (32 - L);
    er = f;
    case (o)
      3'd0: er = (L < 32 && f[L-1]) ? (f | (32'hFFFFFFFF << L)) : f;
      3'd2: begin
        er = (L == 32) ? iv : (iv & ((32'h1 << L) - 1));
        ef = er << (32 - L);
      end
      3'd6: er = 32'(ofs + ffo);
      default: ;
    endcase
    for (int i = 0; i < L; i++) begin
      int q; bit nv;
      q = p + i;
      nv = mbit(q);
      case (o)
        3'd2: nv = iv[L-1-i];
        3'd3: nv = ~nv;
        3'd4: nv = 1'b0;
        3'd5: nv = 1'b1;
        default: ;
      endcase
      model[q >>> 3][7 - (q & 7)] = nv;
    end
    nb = ((p & 7) + L - 1) / 8 + 1;
    @(negedge clk);
    op = o; base_addr = ADDR_W'(base); bit_ofs = 32'(ofs); len_code = lc; ins_val = iv;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(ok);
    check("R11 done seen", 32'(ok), 32'd1);
    check(op_tag(o), result, er);
    check({op_tag(o), " flag"}, flag_field, ef);
    check("R3 first byte", 32'(first_rd), 32'(p >>> 3));
    check("R4 reads", 32'(rd_cnt), 32'(nb));
    check("R4 writes", 32'(wr_cnt), (o >= 3'd2 && o <= 3'd5) ? 32'(nb) : 32'd0);
    for (int i = 0; i < MEM_N; i++)
      if (mem[i] !== model[i]) check($sformatf("R10 byte %0d", i), 32'(mem[i]), 32'(model[i]));
    n_chk++;
  endtask

  initial begin
    for (int c = 0; c < WD_CYC; c++) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    fill_mem(1'b0);
    repeat (3) @(negedge clk);
    check("R1 busy in reset", 32'(busy), 0);
    check("R1 done in reset", 32'(done), 0);
    check("R1 req in reset", 32'(mem_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle req", 32'(mem_req), 0);

    for (int v = 0; v < NVEC; v++)
      run_op(VEC[v][63:61], int'(VEC[v][60:53]), int'($signed(VEC[v][52:37])),
             VEC[v][36:32], VEC[v][31:0], 1'b0);

    // R9: all-zero fields fall back to offset plus length (8 and 32).
    run_op(3'd6, 10, -5, 5'd8, 32'h0, 1'b1);
    run_op(3'd6, 10, 3, 5'd0, 32'h0, 1'b1);
    // R2/R4: 32-bit field at bit 7 of the base reaches five bytes; insert.
    run_op(3'd2, 12, 7, 5'd0, 32'hCAFEF00D, 1'b0);

    // R11: a second start while busy is ignored.
    begin
      bit ok; int dones;
      fill_mem(1'b0);
      @(negedge clk);
      op = 3'd1; base_addr = 16'd20; bit_ofs = 32'd0; len_code = 5'd8; ins_val = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (2) @(negedge clk);
      op = 3'd5; base_addr = 16'd2; bit_ofs = 32'd0; len_code = 5'd16;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done(ok);
      check("R11 first op result", result, 32'(mem[20]));
      check("R11 ignored start no write", 32'(wr_cnt), 0);
      dones = 0;
      for (int c = 0; c < 20; c++) begin
        @(negedge clk);
        if (done) dones++;
      end
      check("R11 no second done", 32'(dones), 0);
      check("R11 memory untouched", 32'(mem[2]), 32'(model[2]));
    end

    // R1: reset in the middle of an operation returns to idle.
    @(negedge clk);
    op = 3'd3; base_addr = 16'd20; bit_ofs = 32'd4; len_code = 5'd0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 busy after mid reset", 32'(busy), 0);
    check("R1 req after mid reset", 32'(mem_req), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 stays idle", 32'(busy), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule